// File: doc/BRIEF.md
# Prefetch Instruction Queue with Branch Folding

This block sits between an instruction fetch port and the dispatch stage of a pipelined core. It requests instruction words ahead of need from an instruction memory and keeps them in a small first-in first-out queue. Each clock, the dispatch side takes the oldest waiting word and issues it to execution. The queue keeps filling while execution holds dispatch back. It keeps draining while the memory is slow to accept requests. So a stall on one side does not always stall the other.

Unconditional branches are resolved on the fetch side and never enter the queue. When a returning word carries the branch opcode, the block computes the target from the word's own address and a signed offset. The sequential request issued in that same cycle is discarded and fetch restarts at the target. Dispatch keeps issuing queued words during all of this, so the branch costs no issue slot whenever another instruction is waiting.

The memory interface has a fixed latency of one clock. A request counts as accepted in a cycle where the request and the memory's ready are both high. The word for that request must be present on the read-data input in the next cycle.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is low at a clock edge, and until the first non-reset edge after it, occupancy is 0, dispatch valid is 0, and the fetch address equals the reset address parameter.
- R2: A word is dispatched (dispatch valid high, with the head word and its address on the outputs) exactly in cycles where the queue is non-empty and dispatch stall is low. Dispatched words follow program order with branches removed, each exactly once.
- R3: Occupancy changes at each clock edge by +1 for a push only, -1 for a dispatch only, and 0 for both or neither. A push is a non-branch word returning from an accepted, not-discarded request.
- R4: The fetch request is high exactly when occupancy plus the number of requests in flight (0 or 1) is below DEPTH, or a dispatch occurs that cycle. Occupancy never exceeds DEPTH.
- R5: After each accepted request, the fetch address advances by one instruction. While the request is not accepted, the address holds.
- R6: A word whose top 6 bits equal 6'b111010 is a branch. Its target is its address plus its low 16 bits taken as a signed offset. A branch is never written into the queue and never dispatched.
- R7: In the cycle a branch word returns, any request accepted in that cycle is discarded and its returned data is ignored. The next fetch address is the branch target.
- R8: In the cycle a branch is resolved, a word is still dispatched if the queue is non-empty and dispatch stall is low.
- R9: While dispatch is stalled, fetching continues until occupancy reaches DEPTH. The request then drops.
- R10: While the memory does not accept requests, dispatch continues until the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_req | output | 1 | Fetch request |
| imem_addr | output | 16 | Fetch address, in instruction units |
| imem_ready | input | 1 | Memory accepts the request this cycle |
| imem_rdata | input | 32 | Word for the request accepted in the previous cycle |
| disp_stall | input | 1 | Execution holds dispatch back |
| disp_valid | output | 1 | A word is dispatched this cycle |
| disp_word | output | 32 | Dispatched instruction word |
| disp_addr | output | 16 | Address of the dispatched word |
| occupancy | output | 3 | Words held in the queue (width grows with DEPTH) |

## Verification
Dispatch valid, the dispatched word, the fetch request and the fetch address are combinational within the cycle, from registered state and the current stall and ready inputs. A memory response is due one clock after acceptance. Its effect appears one further clock later, in occupancy or in the redirected fetch address. The bench drives its inputs at the falling edge and compares every output 1 ns later against a behavioural model. The model is advanced with exactly these latencies, so each result is checked in the cycle it is due. Directed phases fill the queue with dispatch stalled and drain it with fetch stalled. The random phases mix stall densities over a program that holds consecutive branches and a backward branch.

// File: rtl/pfq_pkg.sv
// Shared layout constants and the queue slot type for the prefetch queue.
// Assumes word-addressed instruction memory (one address step per word).
package pfq_pkg;
    localparam int IW    = 32;               // instruction word width
    localparam int AW    = 16;               // address width
    localparam int OPC_W = 6;                // opcode field width (top bits)
    localparam int OFF_W = 16;               // branch offset width (low bits)
    localparam logic [OPC_W-1:0] BR_OPC = 6'b111010;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [IW-1:0] word;
    } slot_t;
endpackage

// File: rtl/pfq_brdec.sv
// Branch recogniser: flags the unconditional branch opcode and forms the
// target as address plus sign-extended offset. Purely combinational.
module pfq_brdec
    import pfq_pkg::*;
(
    input  logic [IW-1:0] word,
    input  logic [AW-1:0] addr,
    output logic          is_branch,
    output logic [AW-1:0] target
);
    logic signed [OFF_W-1:0] off_raw;
    logic        [AW-1:0]    off_ext;

    // decode opcode and extend the offset to the address width
    always_comb begin
        off_raw   = $signed(word[OFF_W-1:0]);
        off_ext   = AW'(off_raw);
        is_branch = (word[IW-1 -: OPC_W] == BR_OPC);
        target    = addr + off_ext;
    end
endmodule

// File: rtl/pfq_ring.sv
// Circular FIFO holding prefetched words. Assumes the writer never pushes
// into a full queue unless a pop happens in the same cycle.
module pfq_ring
    import pfq_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  slot_t         push_slot,
    input  logic          pop,
    output slot_t         head_slot,
    output logic [CW-1:0] count
);
    slot_t         store [DEPTH];
    logic [PW-1:0] head_q, tail_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // write the incoming slot at the tail
    always_ff @(posedge clk) begin
        if (push) store[tail_q] <= push_slot;
    end

    // advance pointers and occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            count  <= '0;
        end else begin
            if (push) tail_q <= step(tail_q);
            if (pop)  head_q <= step(head_q);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign head_slot = store[head_q];

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && count == CW'(DEPTH)) |-> pop);
    p_occ_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    p_no_branch_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_slot.word[IW-1 -: OPC_W] != BR_OPC));
endmodule

// File: rtl/pfq_fetch.sv
// Fetch side: issues sequential requests while queue space is reserved,
// takes the one-cycle-latency response, folds branches and drops the
// wrong-path request. Assumes memory returns data the cycle after accept.
module pfq_fetch
    import pfq_pkg::*;
#(
    parameter  int            DEPTH    = 4,
    parameter  logic [AW-1:0] RESET_PC = '0,
    localparam int            CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          imem_ready,
    input  logic [IW-1:0] imem_rdata,
    input  logic [CW-1:0] q_count,
    input  logic          q_pop,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    output logic          push,
    output slot_t         push_slot,
    output logic          redirect
);
    logic [AW-1:0] pc_q;
    logic          rsp_v_q;
    logic [AW-1:0] rsp_addr_q;
    logic          is_br;
    logic [AW-1:0] br_target;
    logic          accept;

    pfq_brdec u_brdec (
        .word      (imem_rdata),
        .addr      (rsp_addr_q),
        .is_branch (is_br),
        .target    (br_target)
    );

    // request only when a queue slot is reserved for the returning word
    always_comb begin
        imem_req  = ((int'(q_count) + int'(rsp_v_q)) < DEPTH) || q_pop;
        imem_addr = pc_q;
        accept    = imem_req && imem_ready;
        redirect  = rsp_v_q && is_br;
        push      = rsp_v_q && !is_br;
        push_slot = '{addr: rsp_addr_q, word: imem_rdata};
    end

    // program counter and in-flight response tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q       <= RESET_PC;
            rsp_v_q    <= 1'b0;
            rsp_addr_q <= '0;
        end else begin
            rsp_v_q <= accept && !redirect;
            if (accept) rsp_addr_q <= pc_q;
            if (redirect)    pc_q <= br_target;
            else if (accept) pc_q <= pc_q + AW'(1);
        end
    end

    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (imem_req && !imem_ready && !redirect) |=> $stable(imem_addr));
    p_wrong_path_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> !push);
endmodule

// File: rtl/prefetch_queue.sv
// Top of the prefetch instruction queue: fetch side, FIFO and dispatch.
// Dispatch is combinational from the queue head; disp_stall gates it.
module prefetch_queue
    import pfq_pkg::*;
#(
    parameter  int            DEPTH    = 4,
    parameter  logic [AW-1:0] RESET_PC = '0,
    localparam int            CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          imem_req,
    output logic [AW-1:0] imem_addr,
    input  logic          imem_ready,
    input  logic [IW-1:0] imem_rdata,
    input  logic          disp_stall,
    output logic          disp_valid,
    output logic [IW-1:0] disp_word,
    output logic [AW-1:0] disp_addr,
    output logic [CW-1:0] occupancy
);
    logic          push, pop, redirect;
    slot_t         push_slot, head_slot;
    logic [CW-1:0] count;

    pfq_fetch #(.DEPTH(DEPTH), .RESET_PC(RESET_PC)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_ready (imem_ready),
        .imem_rdata (imem_rdata),
        .q_count    (count),
        .q_pop      (pop),
        .imem_req   (imem_req),
        .imem_addr  (imem_addr),
        .push       (push),
        .push_slot  (push_slot),
        .redirect   (redirect)
    );

    pfq_ring #(.DEPTH(DEPTH)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_slot (push_slot),
        .pop       (pop),
        .head_slot (head_slot),
        .count     (count)
    );

    // issue the head word whenever one is waiting and execution allows it
    always_comb begin
        pop        = (count != '0) && !disp_stall;
        disp_valid = pop;
        disp_word  = head_slot.word;
        disp_addr  = head_slot.addr;
        occupancy  = count;
    end

    p_fold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && count != '0 && !disp_stall) |-> disp_valid);
    p_stalled_no_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        disp_stall |-> !disp_valid);
endmodule

// File: tb/tb_prefetch_queue.sv
// Bench: behavioural cycle model of fetch, memory and queue occupancy plus
// a program-order walker, compared against the design on every clock.
`timescale 1ns/1ps
module tb_prefetch_queue;
    import pfq_pkg::*;

    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam logic [31:0] JUNK = 32'h1000_0BAD;

    logic          clk = 0, rst_n = 0;
    logic          imem_req, imem_ready = 0, disp_stall = 1;
    logic [AW-1:0] imem_addr, disp_addr;
    logic [IW-1:0] imem_rdata = '0, disp_word;
    logic          disp_valid;
    logic [CW-1:0] occupancy;

    int checks = 0, fails = 0, folds = 0;
    bit done = 0;

    // model state
    int            m_occ = 0;
    bit            m_inf_v = 0;
    logic [15:0]   m_inf_a = 0, m_pc = 0, walk = 0;
    bit            m_redir_prev = 0;

    always #10 clk = ~clk;

    prefetch_queue #(.DEPTH(DEPTH), .RESET_PC(16'h0000)) dut (
        .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
        .imem_ready(imem_ready), .imem_rdata(imem_rdata), .disp_stall(disp_stall),
        .disp_valid(disp_valid), .disp_word(disp_word), .disp_addr(disp_addr),
        .occupancy(occupancy)
    );

    // test program: forward branches, a branch landing on a branch, one backward branch
    function automatic logic [31:0] prog(input logic [15:0] a);
        logic [15:0] off;
        bit br;
        br = 0; off = 0;
        if (a[2:0] == 3'd5) begin
            br = 1;
            case (a[5:0])
                6'h2D:   off = 16'd16;
                6'h3D:   off = 16'hFFF7;
                6'h35:   off = 16'd10;
                default: off = a[3] ? 16'd2 : 16'd3;
            endcase
        end else if (a[2:0] == 3'd7 && a[4]) begin
            br = 1; off = 16'd1;
        end
        return br ? {6'b111010, 10'h0, off} : {6'b000100, a[9:0], a};
    endfunction

    function automatic bit isbr(input logic [31:0] w);
        return w[31:26] == 6'b111010;
    endfunction

    function automatic logic [15:0] tgt(input logic [15:0] a, input logic [31:0] w);
        return a + w[15:0];
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive at falling edge, compare, then advance the model
    task automatic cycle(input bit ready, input bit stall);
        bit br_res, push, pop, req, acc;
        logic [15:0] e;
        @(negedge clk);
        imem_ready = ready;
        disp_stall = stall;
        imem_rdata = m_inf_v ? prog(m_inf_a) : JUNK;
        #1;
        br_res = m_inf_v && isbr(prog(m_inf_a));
        push   = m_inf_v && !br_res;
        pop    = (m_occ > 0) && !stall;
        req    = ((m_occ + int'(m_inf_v)) < DEPTH) || pop;
        chk(imem_req == req, "R4 request", 32'(imem_req), 32'(req));
        if (req)
            chk(imem_addr == m_pc, m_redir_prev ? "R7 redirect address" : "R5 fetch address",
                32'(imem_addr), 32'(m_pc));
        chk(occupancy == CW'(m_occ), "R3 occupancy", 32'(occupancy), 32'(m_occ));
        chk(disp_valid == pop, "R2 dispatch valid", 32'(disp_valid), 32'(pop));
        if (br_res && m_occ > 0 && !stall) begin
            folds++;
            chk(disp_valid == 1'b1, "R8 fold dispatch", 32'(disp_valid), 32'd1);
        end
        if (pop && disp_valid) begin
            e = walk;
            for (int k = 0; k < 8 && isbr(prog(e)); k++) e = tgt(e, prog(e));
            chk(disp_addr == e, "R2 program order", 32'(disp_addr), 32'(e));
            chk(disp_word == prog(e), "R6 dispatched word", disp_word, prog(e));
            chk(!isbr(disp_word), "R6 no branch issued", disp_word, 32'h0);
            walk = e + 16'd1;
        end
        acc = req && ready;
        m_redir_prev = br_res;
        if (br_res)   m_pc = tgt(m_inf_a, prog(m_inf_a));
        else if (acc) m_pc = m_pc + 16'd1;
        m_inf_v = acc && !br_res;
        if (acc) m_inf_a = m_pc - 16'd1;
        if (acc && br_res) m_inf_a = 16'h0;
        m_occ = m_occ + int'(push) - int'(pop);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(occupancy == '0, "R1 reset occupancy", 32'(occupancy), 32'd0);
        chk(disp_valid == 1'b0, "R1 reset valid", 32'(disp_valid), 32'd0);
        chk(imem_addr == 16'h0000, "R1 reset address", 32'(imem_addr), 32'd0);
        rst_n = 1;
        // fill with dispatch stalled
        for (int i = 0; i < 30; i++) cycle(1'b1, 1'b1);
        chk(occupancy == CW'(DEPTH), "R9 fills to depth", 32'(occupancy), 32'(DEPTH));
        chk(imem_req == 1'b0, "R9 request drops when full", 32'(imem_req), 32'd0);
        // drain with memory not ready
        for (int i = 0; i < 12; i++) cycle(1'b0, 1'b0);
        chk(occupancy == '0, "R10 drains to empty", 32'(occupancy), 32'd0);
        // random mixes of stall densities
        for (int ph = 0; ph < 4; ph++) begin
            int pr, ps;
            pr = (ph == 0) ? 90 : (ph == 1) ? 50 : (ph == 2) ? 25 : 100;
            ps = (ph == 0) ? 10 : (ph == 1) ? 50 : (ph == 2) ? 70 : 0;
            for (int i = 0; i < 800; i++)
                cycle($urandom_range(99) < pr, $urandom_range(99) < ps);
        end
        chk(folds > 0, "R8 fold events seen", 32'(folds), 32'd1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule